// File: doc/BRIEF.md
# Link Transmit Rate Controller

This block sets the bit rate of one Data-Strobe link transmitter. It divides a 200 MHz reference clock by an integer ratio and emits a one-cycle bit-enable pulse that advances the serializer by one bit. A 3-bit rate code selects the ratio. The link runs at 10 Mbit/s after reset, and the slowest legal rate is 1.25 Mbit/s.

When the power-save option is on and the serializer reports that the next token is a Null, the block drops any programmed rate faster than 10 Mbit/s to 10 Mbit/s. When a data or control token is pending, it goes back to the programmed rate. All rate changes, whether from reprogramming or from power save, take effect only at a token boundary that the serializer signals. The divider restarts at each switch, so every bit period matches the ratio of the rate in force.

Top module: `link_rate_ctrl`

## Requirements
- R1: In reset, and until the first token boundary after reset, the active rate code is 4 (10 Mbit/s, divide by 20) and `ps_active` is 0.
- R2: Rate code c gives a bit-enable spacing of 1, 2, 4 or 8 clock cycles for c = 0, 1, 2, 3, and 20, 40, 80 or 160 cycles for c = 4, 5, 6, 7. That is 200, 100, 50, 25, 10, 5, 2.5 and 1.25 Mbit/s from the 200 MHz reference.
- R3: A change of `cfg_rate`, `cfg_psave` or `next_null` in a cycle where `tok_end` is low has no effect on `rate_code` or on the bit-enable spacing.
- R4: At a token boundary with `cfg_psave` = 1, `next_null` = 1 and `cfg_rate` < 4, the active code becomes 4 and `ps_active` goes to 1.
- R5: At a token boundary with `cfg_psave` = 0, the active code becomes `cfg_rate`, whatever `next_null` is.
- R6: At a token boundary with `next_null` = 0, the active code becomes `cfg_rate` and `ps_active` goes to 0. The first bit-enable of that token already uses the programmed spacing.
- R7: At a token boundary with `cfg_rate` >= 4, the active code becomes `cfg_rate` even when power save is on and the next token is a Null.
- R8: When a boundary changes the active code, the divider restarts. The next bit-enable comes exactly the new ratio of cycles after the clock edge that samples `tok_end`. No bit period differs from the ratio of the code in force.
- R9: `ps_active` is 1 exactly when the code in force was substituted by power save at the last boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 200 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rate | input | 3 | Programmed rate code |
| cfg_psave | input | 1 | Power-save enable |
| tok_end | input | 1 | Token boundary strobe from the serializer, sampled on the clock edge |
| next_null | input | 1 | 1 when the token about to be sent is a Null |
| bit_en | output | 1 | One-cycle pulse per transmitted bit |
| rate_code | output | 3 | Rate code currently in force |
| ps_active | output | 1 | Reduced power-save rate is in force |

## Verification
The bench tries every combination of rate code, power-save enable and Null indication at a token boundary. It starts each time from the code left by the previous combination, so it covers both switches and non-switches. For each combination it measures the distance from the boundary to the first bit-enable and the spacing of the next one. This separates a missed counter restart from a wrong ratio, and it separates power-save substitution from a plain use of the programmed code. A separate pattern changes the inputs while no boundary is signalled, which shows that the rate is held until the token ends.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

    localparam int CODE_W     = 3;
    localparam int NUM_CODES  = 1 << CODE_W;
    // codes below FAST_TIERS divide by a power of two
    localparam int FAST_TIERS = 4;
    // first ratio of the slow tier, doubled per code step
    localparam int SLOW_BASE  = 20;
    // code used for the power-save rate and after reset
    localparam int PS_CODE    = 4;
    localparam int RESET_CODE = 4;
    localparam int MAX_DIV    = SLOW_BASE << (NUM_CODES - 1 - FAST_TIERS);
    localparam int CNT_W      = $clog2(MAX_DIV);

    typedef logic [CODE_W-1:0] rate_code_t;
    typedef logic [CNT_W-1:0]  bit_cnt_t;

    typedef struct packed {
        rate_code_t code;
        logic       reduced;
    } rate_sel_t;

    function automatic int unsigned div_of(rate_code_t c);
        if (int'(c) < FAST_TIERS)
            return 32'd1 << c;
        else
            return SLOW_BASE << (int'(c) - FAST_TIERS);
    endfunction

    function automatic logic above_ps_rate(rate_code_t c);
        return int'(c) < PS_CODE;
    endfunction

endpackage

// File: rtl/lrc_target.sv
module lrc_target
    import lrc_pkg::*;
(
    input  rate_code_t cfg_rate,
    input  logic       cfg_psave,
    input  logic       next_null,
    output rate_sel_t  tgt
);

    logic substitute;

    always_comb begin
        substitute = cfg_psave && next_null && above_ps_rate(cfg_rate);
        if (substitute) begin
            tgt.code    = rate_code_t'(PS_CODE);
            tgt.reduced = 1'b1;
        end else begin
            tgt.code    = cfg_rate;
            tgt.reduced = 1'b0;
        end
    end

endmodule

// File: rtl/lrc_rate_reg.sv
module lrc_rate_reg
    import lrc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tok_end,
    input  rate_sel_t tgt,
    output rate_sel_t cur,
    output logic      restart
);

    rate_sel_t cur_q;

    assign restart = tok_end && (tgt.code != cur_q.code);
    assign cur     = cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.code    <= rate_code_t'(RESET_CODE);
            cur_q.reduced <= 1'b0;
        end else if (tok_end) begin
            cur_q <= tgt;
        end
    end

endmodule

// File: rtl/lrc_divider.sv
module lrc_divider
    import lrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  rate_code_t code,
    output logic       bit_en
);

    bit_cnt_t term [NUM_CODES];
    bit_cnt_t cnt_q;
    logic     at_term;

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_term
        assign term[g] = bit_cnt_t'(div_of(rate_code_t'(g)) - 1);
    end

    assign at_term = (cnt_q == term[code]);
    assign bit_en  = at_term;

    always_ff @(posedge clk) begin
        if (rst || restart || at_term)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/link_rate_ctrl.sv
module link_rate_ctrl
    import lrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] cfg_rate,
    input  logic       cfg_psave,
    input  logic       tok_end,
    input  logic       next_null,
    output logic       bit_en,
    output logic [2:0] rate_code,
    output logic       ps_active
);

    rate_sel_t tgt;
    rate_sel_t cur;
    logic      restart;

    lrc_target u_target (
        .cfg_rate (cfg_rate),
        .cfg_psave(cfg_psave),
        .next_null(next_null),
        .tgt      (tgt)
    );

    lrc_rate_reg u_rate (
        .clk    (clk),
        .rst    (rst),
        .tok_end(tok_end),
        .tgt    (tgt),
        .cur    (cur),
        .restart(restart)
    );

    lrc_divider u_div (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .code   (cur.code),
        .bit_en (bit_en)
    );

    assign rate_code = cur.code;
    assign ps_active = cur.reduced;

endmodule

// File: rtl/lrc_checker.sv
module lrc_checker
    import lrc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] cfg_rate,
    input logic       cfg_psave,
    input logic       tok_end,
    input logic       next_null,
    input logic       bit_en,
    input logic [2:0] rate_code,
    input logic       ps_active
);

    localparam int GAP_W = CNT_W + 1;

    logic             armed;
    rate_code_t       rc_q;
    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] gap_eff;

    always_comb gap_eff = (rate_code != rc_q) ? GAP_W'(1) : gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            rc_q  <= rate_code_t'(RESET_CODE);
            gap_q <= GAP_W'(1);
        end else begin
            armed <= 1'b1;
            rc_q  <= rate_code;
            if (bit_en)
                gap_q <= GAP_W'(1);
            else if (gap_eff != '1)
                gap_q <= gap_eff + 1'b1;
            else
                gap_q <= gap_eff;
            // R1: values seen in the first cycle after reset
            if (!armed)
                assert_reset_code_R1: assert (rate_code == rate_code_t'(RESET_CODE) && !ps_active)
                    else $error("R1 reset code");
            // R2 and R8: spacing equals the ratio of the code in force
            if (bit_en)
                assert_bit_spacing_R8: assert (32'(gap_eff) == div_of(rate_code))
                    else $error("R8 spacing %0d code %0d", gap_eff, rate_code);
        end
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(tok_end)) |-> $stable(rate_code) && $stable(ps_active));

    assert_ps_code_R4: assert property (@(posedge clk) disable iff (rst)
        ps_active |-> (rate_code == rate_code_t'(PS_CODE)));

    assert_no_psave_R5: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(tok_end) && !$past(cfg_psave)) |-> (rate_code == $past(cfg_rate)));

    assert_real_token_R6: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(tok_end) && !$past(next_null)) |-> (rate_code == $past(cfg_rate) && !ps_active));

    assert_slow_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(tok_end) && ($past(cfg_rate) >= 3'(PS_CODE))) |-> (rate_code == $past(cfg_rate)));

    assert_ps_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(tok_end)) |->
            (ps_active == ($past(cfg_psave) && $past(next_null) && ($past(cfg_rate) < 3'(PS_CODE)))));

endmodule

bind link_rate_ctrl lrc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_rate (cfg_rate),
    .cfg_psave(cfg_psave),
    .tok_end  (tok_end),
    .next_null(next_null),
    .bit_en   (bit_en),
    .rate_code(rate_code),
    .ps_active(ps_active)
);

// File: tb/link_rate_ctrl_test.sv
module link_rate_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_rate = 3'd0;
    logic       cfg_psave = 1'b0;
    logic       tok_end = 1'b0;
    logic       next_null = 1'b0;
    logic       bit_en;
    logic [2:0] rate_code;
    logic       ps_active;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    int model_code;

    always #2.5 clk = ~clk;

    link_rate_ctrl uut (
        .clk      (clk),
        .rst      (rst),
        .cfg_rate (cfg_rate),
        .cfg_psave(cfg_psave),
        .tok_end  (tok_end),
        .next_null(next_null),
        .bit_en   (bit_en),
        .rate_code(rate_code),
        .ps_active(ps_active)
    );

    function automatic int ratio(int c);
        if (c < 4) return 1 << c;
        return 20 << (c - 4);
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // count negedges until bit_en is seen; k=1 is the first negedge sampled
    task automatic wait_pulse(output int k);
        k = 0;
        for (int i = 1; i <= 400; i++) begin
            @(negedge clk);
            if (bit_en) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic boundary(input int code, input bit ps, input bit nul);
        int exp_code, exp_ps, k1, k2;
        @(negedge clk);
        cfg_rate  = 3'(code);
        cfg_psave = ps;
        next_null = nul;
        tok_end   = 1'b1;
        exp_ps    = (ps && nul && code < 4) ? 1 : 0;
        exp_code  = exp_ps ? 4 : code;
        @(negedge clk);
        tok_end = 1'b0;
        if (bit_en) k1 = 1;
        else begin
            wait_pulse(k1);
            k1 = k1 + 1;
        end
        check(exp_ps ? "R4 code" : (!ps ? "R5 code" : (!nul ? "R6 code" : "R7 code")),
              int'(rate_code), exp_code);
        check("R9 ps_active", int'(ps_active), exp_ps);
        if (exp_code != model_code)
            check("R8 first bit after switch", k1, ratio(exp_code));
        wait_pulse(k2);
        check("R2 bit spacing", k2, ratio(exp_code));
        model_code = exp_code;
    endtask

    initial begin
        int k;
        repeat (4) @(negedge clk);
        check("R1 code in reset", int'(rate_code), 4);
        check("R1 ps_active in reset", int'(ps_active), 0);
        rst = 1'b0;
        model_code = 4;
        wait_pulse(k);
        wait_pulse(k);
        check("R1 spacing after reset", k, 20);
        check("R1 code after reset", int'(rate_code), 4);

        // R3: inputs change with no boundary
        cfg_rate  = 3'd0;
        cfg_psave = 1'b1;
        next_null = 1'b1;
        wait_pulse(k);
        check("R3 spacing held", k, 20);
        check("R3 code held", int'(rate_code), 4);
        cfg_rate  = 3'd7;
        next_null = 1'b0;
        wait_pulse(k);
        check("R3 spacing held again", k, 20);

        for (int c = 0; c < 8; c++)
            for (int p = 0; p < 2; p++)
                for (int n = 0; n < 2; n++)
                    boundary(c, p[0], n[0]);

        // R6: leave power save toward a fast rate
        boundary(0, 1'b1, 1'b1);
        boundary(0, 1'b1, 1'b0);
        boundary(2, 1'b1, 1'b1);
        boundary(1, 1'b1, 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule